// File: doc/BRIEF.md
# Cascadable Quadrature Position Counter

This block turns a two-phase incremental encoder signal into a position count. Each phase input first goes through a two-flop synchroniser. The synchronised pair is then decoded on every edge of either phase, which gives four counts per encoder cycle. The direction of each count comes from which phase leads.

The block holds two 16-bit counter channels. The lower channel follows the encoder. When the chain control is set, the upper channel counts on the lower channel's wrap events: it steps up on an overflow and down on an underflow. Together the two channels then form one 32-bit position.

Software reaches the count through a plain register port. A write loads either half. Reading the lower half also latches the upper half into a shadow register, so a following read of the upper half returns a coherent 32-bit value. The port has no handshake: a write takes effect at the clock edge where it is presented, and read data is combinational, so no back-pressure is possible or needed.

Top module: `qpc_cascade`

## Requirements
- R1: After reset, both counter halves and the shadow read zero, and all four wrap strobes are low.
- R2: The phase pair {A,B} forms the forward sequence 00, 10, 11, 01, 00. Each single-phase change along this sequence (A leads B) adds one to the lower count.
- R3: Each single-phase change against the forward sequence (B leads A) subtracts one from the lower count.
- R4: When both phases change between two synchronised samples, the count does not change.
- R5: A phase change that is present at a rising clock edge is first visible in the lower count after the third rising edge, counting that edge as the first.
- R6: When the lower count wraps from 0xFFFF to 0x0000, lo_ovf is high for exactly one cycle, and that cycle is the one in which the count reads 0x0000.
- R7: When the lower count wraps from 0x0000 to 0xFFFF, lo_unf is high for exactly one cycle, and that cycle is the one in which the count reads 0xFFFF.
- R8: With chain_en high, the upper count steps up by one on the same edge as a lower overflow, and down by one on the same edge as a lower underflow.
- R9: With chain_en low, a lower wrap leaves the upper count unchanged.
- R10: wr_en with wr_hi=0 loads the lower half, and with wr_hi=1 loads the upper half. A load takes priority over a count on that half in the same cycle.
- R11: rd_data shows the live lower count when rd_hi=0. When rd_hi=1 it shows the shadow, which rd_en with rd_hi=0 loads from the upper count at the clock edge. Later changes to the upper count do not reach the shadow until the next such read.
- R12: hi_ovf and hi_unf pulse for one cycle when the upper count wraps upward or downward, with the same timing as the lower strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| chain_en | input | 1 | Upper half counts on lower wraps when high |
| wr_en | input | 1 | Load strobe |
| wr_hi | input | 1 | Load target: 0 lower, 1 upper |
| wr_data | input | 16 | Load value |
| rd_en | input | 1 | Read strobe; with rd_hi=0 it latches the upper half into the shadow |
| rd_hi | input | 1 | Read select: 0 live lower, 1 shadow |
| rd_data | output | 16 | Read value |
| lo_ovf | output | 1 | Lower half overflow strobe |
| lo_unf | output | 1 | Lower half underflow strobe |
| hi_ovf | output | 1 | Upper half overflow strobe |
| hi_unf | output | 1 | Upper half underflow strobe |

## Verification
The bench builds the block with its default 16-bit channel width and two synchroniser stages. It uses loads of values next to 0xFFFF and 0x0000 so that both halves, and the full 32-bit value, wrap within a few encoder steps. A seeded random walk then starts from a preload just below the lower wrap. Its legal steps, illegal double changes and idle samples carry the count back and forth across the lower-to-upper boundary, and the reads there check that the shadow stays coherent.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_BAD  = 2'd3
  } qpc_step_e;
endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      a,
  input  logic      b,
  output qpc_step_e step
);
  logic prev_a, prev_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
    end else begin
      prev_a <= a;
      prev_b <= b;
    end
  end

  // A change on one phase: direction from the new A against the old B.
  always_comb begin
    case ({a ^ prev_a, b ^ prev_b})
      2'b00:   step = STEP_NONE;
      2'b11:   step = STEP_BAD;
      default: step = (a ^ prev_b) ? STEP_UP : STEP_DN;
    endcase
  end

  AST_DECODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (a != prev_a && b != prev_b) |-> (step == STEP_BAD)); // R4
endmodule

// File: rtl/qpc_counter.sv
module qpc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         up,
  input  logic         dn,
  output logic [W-1:0] cnt,
  output logic         wrap_up,
  output logic         wrap_dn,
  output logic         ovf_o,
  output logic         unf_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic go_up, go_dn;
  assign go_up   = up && !dn && !ld;
  assign go_dn   = dn && !up && !ld;
  assign wrap_up = go_up && (cnt == MAXV);
  assign wrap_dn = go_dn && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= wrap_up;
      unf_o <= wrap_dn;
      if (ld)         cnt <= ld_val;
      else if (go_up) cnt <= cnt + W'(1);
      else if (go_dn) cnt <= cnt - W'(1);
    end
  end

  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (cnt == '0)); // R6
  AST_UNF_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> (cnt == MAXV)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o)); // R12
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val))); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !up && !dn) |=> $stable(cnt)); // R9
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !dn && !ld) |=> (cnt == $past(cnt) + W'(1))); // R2
endmodule

// File: rtl/qpc_cascade.sv
module qpc_cascade
  import qpc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             chain_en,
  input  logic             wr_en,
  input  logic             wr_hi,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rd_hi,
  output logic [CNT_W-1:0] rd_data,
  output logic             lo_ovf,
  output logic             lo_unf,
  output logic             hi_ovf,
  output logic             hi_unf
);
  logic [1:0]       ph_sync;
  qpc_step_e        step;
  logic [CNT_W-1:0] lo_cnt, hi_cnt, shadow;
  logic             lo_wrap_up, lo_wrap_dn;
  logic             hi_wrap_up, hi_wrap_dn;
  logic             lo_ld, hi_ld;

  assign lo_ld = wr_en && !wr_hi;
  assign hi_ld = wr_en &&  wr_hi;

  qpc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({phase_a, phase_b}), .q(ph_sync)
  );

  qpc_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .a(ph_sync[1]), .b(ph_sync[0]), .step(step)
  );

  qpc_counter #(.W(CNT_W)) u_lo (
    .clk(clk), .rst_n(rst_n),
    .ld(lo_ld), .ld_val(wr_data),
    .up(step == STEP_UP), .dn(step == STEP_DN),
    .cnt(lo_cnt), .wrap_up(lo_wrap_up), .wrap_dn(lo_wrap_dn),
    .ovf_o(lo_ovf), .unf_o(lo_unf)
  );

  qpc_counter #(.W(CNT_W)) u_hi (
    .clk(clk), .rst_n(rst_n),
    .ld(hi_ld), .ld_val(wr_data),
    .up(chain_en && lo_wrap_up), .dn(chain_en && lo_wrap_dn),
    .cnt(hi_cnt), .wrap_up(hi_wrap_up), .wrap_dn(hi_wrap_dn),
    .ovf_o(hi_ovf), .unf_o(hi_unf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                shadow <= '0;
    else if (rd_en && !rd_hi)  shadow <= hi_cnt;
  end

  assign rd_data = rd_hi ? shadow : lo_cnt;

  AST_CHAIN_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && lo_wrap_up && !hi_ld) |=> (hi_cnt == $past(hi_cnt) + CNT_W'(1))); // R8
  AST_CHAIN_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && lo_wrap_dn && !hi_ld) |=> (hi_cnt == $past(hi_cnt) - CNT_W'(1))); // R8
  AST_UNCHAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_en && !hi_ld) |=> $stable(hi_cnt)); // R9
  AST_BAD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_BAD && !lo_ld) |=> $stable(lo_cnt)); // R4
  AST_SHADOW_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hi) |=> (shadow == $past(hi_cnt))); // R11
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !rd_hi) |=> $stable(shadow)); // R11
  AST_HI_WRAP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wrap_up |-> (chain_en && lo_wrap_up)); // R12
endmodule

// File: tb/qpc_cascade_test.sv
module qpc_cascade_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_a = 1'b0, phase_b = 1'b0, chain_en = 1'b1;
  logic        wr_en = 1'b0, wr_hi = 1'b0, rd_en = 1'b0, rd_hi = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        lo_ovf, lo_unf, hi_ovf, hi_unf;

  int n_run = 0, n_fail = 0;
  int c_lo_ovf = 0, c_lo_unf = 0, c_hi_ovf = 0, c_hi_unf = 0;
  int bad_ovf_val = 0;
  int idx = 0;
  logic [15:0] e_lo = '0, e_hi = '0;
  int e_lo_ovf = 0, e_lo_unf = 0, e_hi_ovf = 0, e_hi_unf = 0;

  always #4 clk = ~clk;

  qpc_cascade uut (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .chain_en(chain_en), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .rd_en(rd_en), .rd_hi(rd_hi), .rd_data(rd_data),
    .lo_ovf(lo_ovf), .lo_unf(lo_unf), .hi_ovf(hi_ovf), .hi_unf(hi_unf)
  );

  // strobe monitor, sampled away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (lo_ovf) c_lo_ovf++;
      if (lo_unf) c_lo_unf++;
      if (hi_ovf) c_hi_ovf++;
      if (hi_unf) c_hi_unf++;
      if (lo_ovf && !rd_hi && rd_data != 16'h0000) bad_ovf_val++;
    end
  end

  function automatic logic [1:0] gray(input int i);
    case (i & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  // expected signed step from an index move
  function automatic int delta(input int from, input int to);
    case ((to - from) & 3)
      1: return 1;
      3: return -1;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_step(input int d);
    if (d == 1) begin
      if (e_lo == 16'hFFFF) begin
        e_lo_ovf++;
        if (chain_en) begin
          if (e_hi == 16'hFFFF) e_hi_ovf++;
          e_hi = e_hi + 16'd1;
        end
      end
      e_lo = e_lo + 16'd1;
    end else if (d == -1) begin
      if (e_lo == 16'h0000) begin
        e_lo_unf++;
        if (chain_en) begin
          if (e_hi == 16'h0000) e_hi_unf++;
          e_hi = e_hi - 16'd1;
        end
      end
      e_lo = e_lo - 16'd1;
    end
  endtask

  task automatic move(input int to);
    @(negedge clk);
    {phase_a, phase_b} = gray(to);
    model_step(delta(idx, to));
    idx = to & 3;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic hi, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_hi = hi; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    if (hi) e_hi = v; else e_lo = v;
  endtask

  task automatic rd32(output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_hi = 1'b0;
    #1 v[15:0] = rd_data;
    @(negedge clk);
    rd_en = 1'b0; rd_hi = 1'b1;
    #1 v[31:16] = rd_data;
    rd_hi = 1'b0;
  endtask

  task automatic chk_pos(input string req);
    logic [31:0] v;
    rd32(v);
    chk(req, v, {e_hi, e_lo});
  endtask

  task automatic chk_strobes(input string req);
    chk({req, " lo_ovf count"}, c_lo_ovf, e_lo_ovf);
    chk({req, " lo_unf count"}, c_lo_unf, e_lo_unf);
    chk({req, " hi_ovf count"}, c_hi_ovf, e_hi_ovf);
    chk({req, " hi_unf count"}, c_hi_unf, e_hi_unf);
  endtask

  initial begin
    #1500000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 lower", rd_data, 16'h0);
    chk("R1 strobes", {lo_ovf, lo_unf, hi_ovf, hi_unf}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pos("R1 value");

    // R5 latency: change present at the next rising edge
    @(negedge clk);
    {phase_a, phase_b} = 2'b10;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R5 not before third edge", rd_data, 16'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R5 at third edge", rd_data, 16'h1);
    idx = 1; e_lo = 16'h1;

    // R2 forward on all four edges
    move(2); move(3); move(0); move(1);
    chk_pos("R2 four forward edges");
    // R3 reverse
    move(0); move(3); move(2);
    chk_pos("R3 three reverse edges");
    // R4 both phases change
    move(0);
    chk_pos("R4 double change ignored");
    move(2);
    chk_pos("R4 double change back ignored");

    // R10 loads, R6/R8 overflow into the upper half
    wr(1'b0, 16'hFFFE);
    wr(1'b1, 16'h0005);
    chk_pos("R10 loads");
    move(3); move(0);
    chk_pos("R6 R8 carry into upper");
    chk_strobes("R6");
    chk("R6 strobe shows zero count", bad_ovf_val, 0);
    // R7/R8 underflow
    move(3);
    chk_pos("R7 R8 borrow from upper");
    chk_strobes("R7");

    // R12 full 32-bit wrap both ways
    wr(1'b1, 16'hFFFF);
    wr(1'b0, 16'hFFFF);
    move(0);
    chk_pos("R12 32-bit overflow");
    chk_strobes("R12 up");
    move(3);
    chk_pos("R12 32-bit underflow");
    chk_strobes("R12 down");

    // R9 chain disabled
    chain_en = 1'b0;
    wr(1'b1, 16'h1234);
    move(0); move(3); move(2);
    chk_pos("R9 upper held while unchained");
    chk_strobes("R9");
    chain_en = 1'b1;

    // R11 shadow coherence
    rd32(v);
    wr(1'b1, 16'hBEEF);
    @(negedge clk);
    rd_hi = 1'b1;
    #1 chk("R11 shadow keeps old upper", rd_data, 16'h1234);
    rd_hi = 1'b0;
    chk_pos("R11 fresh read sees new upper");

    // random walk around the lower wrap
    wr(1'b0, 16'hFFF8);
    wr(1'b1, 16'h0000);
    for (int k = 0; k < 300; k++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4)      move(idx + 1);
      else if (r < 7) move(idx + 3);
      else if (r < 8) move(idx + 2);
      else            move(idx);
      if (k % 5 == 0) chk_pos("R2 R3 R4 R8 random walk");
    end
    chk_pos("R8 random walk end");
    chk_strobes("R6 R7 R12 random walk");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule